// File: doc/BRIEF.md
# Capture Frame Buffer Recycler

This block keeps the base addresses of the frame buffers used by a camera capture engine that writes through two destination slots. Software adds empty buffers to a pool, starts capture, and collects filled buffers from a ring queue. Each time the capture engine signals that a slot has finished a frame, the recycler moves that slot's address into the filled queue and refills the slot from the pool. This lets capture continue across frames without software rewriting the slot addresses.

When the pool has no empty buffer left, the finished slot is pointed at the buffer the other slot already uses. Capture keeps running into that buffer, and the frame just finished is not recorded. A done report naming both slots in one cycle is ambiguous, so it is dropped. Stopping capture returns the buffers held by the slots to the pool.

Top module: `fbuf_recycler`

## Requirements
- R1: A start request is refused, pulsing `start_err_o` and leaving capture idle, when the pool holds fewer than two addresses or capture is already running. On a successful start, slot 0 takes the most recently pushed pool address and slot 1 takes the one pushed before it. The active count becomes 2.
- R2: The active count never exceeds 2.
- R3: While running, a `done_i` value of 2'b11 queues nothing. It also leaves both slot addresses and the active count unchanged.
- R4: While running, a done on exactly one slot (`done_i` bit 0 is slot 0, bit 1 is slot 1) queues that slot's address as full when the active count is 2 and the full queue holds fewer than QDEPTH entries. Queuing lowers the active count by one.
- R5: After a single-slot done, if fewer than two buffers are active and the pool is not empty, the finished slot takes the pool's top address and the active count rises by one.
- R6: After a single-slot done, if fewer than two buffers are active and the pool is empty, the finished slot takes the other slot's address and the active count stays at 1.
- R7: A single-slot done that finds the full queue holding QDEPTH entries queues nothing. It keeps the active count at 2 and leaves the slot address unchanged.
- R8: Filled addresses leave the full queue in the order they entered, including across index wrap-around. Each pop answers one cycle later with `pop_valid_o` and `pop_addr_o`.
- R9: A pop on an empty full queue answers one cycle later with `pop_err_o` and no `pop_valid_o`.
- R10: Stop clears the active count and the running state. It pushes the active slot addresses into the pool: slot 0 first, then slot 1 when two buffers are active.
- R11: A push is refused, pulsing `push_err_o` and storing nothing, when the pool already holds POOL_DEPTH addresses. It is also refused when start, stop or any done input is raised in the same cycle, which `push_ready_o` shows by going low.
- R12: `frame_done_o` pulses once, in the cycle after the done input, for every address that enters the full queue.
- R13: Done inputs while capture is not running change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin capture |
| stop_i | input | 1 | Request to end capture |
| push_i | input | 1 | Push an empty buffer address into the pool |
| push_addr_i | input | ADDR_W | Address to push |
| push_ready_o | output | 1 | Low when a push in this cycle would collide with another operation |
| push_err_o | output | 1 | Pulse: previous push refused |
| pop_i | input | 1 | Pop a filled address from the full queue |
| pop_valid_o | output | 1 | Pulse: `pop_addr_o` carries a popped address |
| pop_addr_o | output | ADDR_W | Popped filled buffer address |
| pop_err_o | output | 1 | Pulse: previous pop found the queue empty |
| done_i | input | 2 | Per-slot frame finished flags |
| slot0_addr_o | output | ADDR_W | Destination address for slot 0 |
| slot1_addr_o | output | ADDR_W | Destination address for slot 1 |
| active_o | output | 2 | Number of distinct buffers held by the slots |
| running_o | output | 1 | Capture is running |
| start_err_o | output | 1 | Pulse: previous start refused |
| frame_done_o | output | 1 | Pulse: one address entered the full queue |

## Verification
The hardest state to reach is a full queue met by a done report while both slots are active. Getting there needs the pool drained, several frames queued with no pops, and then the pool refilled so that the shared slot is reloaded and the active count climbs back to 2. The stimulus follows a scripted sequence of pushes and single-slot dones that drains the pool, drops into the shared-address state, refills with one push and then hits the full queue. Afterwards, queue pops crossing the ring wrap are checked against a scoreboard. The contents of the pool after a stop are read back through a later start.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  // Advance a ring index, returning to zero at the ring size.
  function automatic int unsigned ring_step(input int unsigned idx, input int unsigned size);
    int unsigned n;
    n = idx + 1;
    if (n >= size) n = 0;
    return n;
  endfunction

  // Number of entries between read and write index in a ring of the given size.
  function automatic int unsigned ring_level(input int unsigned rd, input int unsigned wr,
                                             input int unsigned size);
    if (wr >= rd) return wr - rd;
    return wr + size - rd;
  endfunction

endpackage

// File: rtl/fbr_pool.sv
module fbr_pool #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_n_i,
  input  logic [AW-1:0] push_a_i,
  input  logic [AW-1:0] push_b_i,
  input  logic [1:0]    pop_n_i,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] top_o,
  output logic [AW-1:0] second_o
);

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;

  // Entries written at cnt (first) and cnt+1 (second) on a push.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_n_i != 2'd0 && CW'(i) == cnt_q)
        mem[i] <= push_a_i;
      else if (push_n_i == 2'd2 && CW'(i) == cnt_q + CW'(1))
        mem[i] <= push_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
  end

  always_comb begin
    top_o    = '0;
    second_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i + 1) == cnt_q) top_o    = mem[i];
      if (CW'(i + 2) == cnt_q) second_o = mem[i];
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fbr_ring.sv
module fbr_ring
  import fbr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 3,
  parameter int QW     = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          rd_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_err_o,
  output logic [QW-1:0] level_o
);

  localparam int RSZ = QDEPTH + 1;

  logic [AW-1:0] mem [RSZ];
  logic [QW-1:0] wr_idx, rd_idx;
  logic          rd_take;

  assign level_o = QW'(ring_level(32'(rd_idx), 32'(wr_idx), RSZ));
  assign rd_take = rd_i && (level_o != '0);

  always_ff @(posedge clk) begin
    if (wr_i) mem[wr_idx] <= wr_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx     <= '0;
      rd_idx     <= '0;
      rd_valid_o <= 1'b0;
      rd_err_o   <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      rd_valid_o <= rd_take;
      rd_err_o   <= rd_i && !rd_take;
      if (wr_i) wr_idx <= QW'(ring_step(32'(wr_idx), RSZ));
      if (rd_take) begin
        rd_addr_o <= mem[rd_idx];
        rd_idx    <= QW'(ring_step(32'(rd_idx), RSZ));
      end
    end
  end

endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl #(
  parameter int AW     = 32,
  parameter int DEPTH  = 4,
  parameter int QDEPTH = 3,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int QW     = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [1:0]    done_i,
  input  logic [CW-1:0] pool_cnt_i,
  input  logic [AW-1:0] pool_top_i,
  input  logic [AW-1:0] pool_second_i,
  input  logic [QW-1:0] ring_level_i,
  output logic [1:0]    pool_push_n_o,
  output logic [AW-1:0] pool_push_a_o,
  output logic [AW-1:0] pool_push_b_o,
  output logic [1:0]    pool_pop_n_o,
  output logic          ring_wr_o,
  output logic [AW-1:0] ring_addr_o,
  output logic          ev_queue_o,
  output logic          ev_reload_o,
  output logic          ev_share_o,
  output logic          ev_skip_o,
  output logic          push_ready_o,
  output logic          push_err_o,
  output logic [AW-1:0] slot0_addr_o,
  output logic [AW-1:0] slot1_addr_o,
  output logic [1:0]    active_o,
  output logic          running_o,
  output logic          start_err_o,
  output logic          frame_done_o
);

  logic          running_q;
  logic [1:0]    act_q, act_mid, ret_n;
  logic [AW-1:0] slot_q [2];
  logic          stop_go, start_go, done_ok, single, need, push_go, idx;
  logic [CW-1:0] room;

  assign push_ready_o = !(start_i || stop_i || (done_i != 2'b00));

  assign stop_go  = stop_i && running_q;
  assign start_go = start_i && !stop_i && !running_q && (pool_cnt_i >= CW'(2));
  assign done_ok  = running_q && !stop_i && (done_i != 2'b00);
  assign single   = done_ok && (done_i[0] ^ done_i[1]);
  assign idx      = done_i[1];

  assign ev_skip_o   = done_ok && (done_i == 2'b11);
  assign ev_queue_o  = single && (act_q == 2'd2) && (ring_level_i < QW'(QDEPTH));
  assign act_mid     = act_q - {1'b0, ev_queue_o};
  assign need        = single && (act_mid < 2'd2);
  assign ev_reload_o = need && (pool_cnt_i != '0);
  assign ev_share_o  = need && (pool_cnt_i == '0);
  assign push_go     = push_i && push_ready_o && (pool_cnt_i < CW'(DEPTH));

  // Slots returned on stop are limited by the free room in the pool.
  assign room  = CW'(DEPTH) - pool_cnt_i;
  assign ret_n = (CW'(act_q) > room) ? room[1:0] : act_q;

  always_comb begin
    pool_pop_n_o  = 2'd0;
    pool_push_n_o = 2'd0;
    pool_push_a_o = push_addr_i;
    pool_push_b_o = slot_q[1];
    if (start_go)         pool_pop_n_o = 2'd2;
    else if (ev_reload_o) pool_pop_n_o = 2'd1;
    if (stop_go) begin
      pool_push_n_o = ret_n;
      pool_push_a_o = slot_q[0];
    end else if (push_go) begin
      pool_push_n_o = 2'd1;
    end
  end

  assign ring_wr_o   = ev_queue_o;
  assign ring_addr_o = slot_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q    <= 1'b0;
      act_q        <= 2'd0;
      slot_q[0]    <= '0;
      slot_q[1]    <= '0;
      start_err_o  <= 1'b0;
      push_err_o   <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      start_err_o  <= start_i && !stop_i && !start_go;
      push_err_o   <= push_i && !push_go;
      frame_done_o <= ev_queue_o;
      if (stop_go) begin
        running_q <= 1'b0;
        act_q     <= 2'd0;
      end else if (start_go) begin
        running_q <= 1'b1;
        act_q     <= 2'd2;
        slot_q[0] <= pool_top_i;
        slot_q[1] <= pool_second_i;
      end else if (single) begin
        act_q <= act_mid + {1'b0, ev_reload_o};
        if (ev_reload_o)     slot_q[idx] <= pool_top_i;
        else if (ev_share_o) slot_q[idx] <= slot_q[~idx];
      end
    end
  end

  assign slot0_addr_o = slot_q[0];
  assign slot1_addr_o = slot_q[1];
  assign active_o     = act_q;
  assign running_o    = running_q;

endmodule

// File: rtl/fbuf_recycler.sv
module fbuf_recycler #(
  parameter int ADDR_W     = 32,
  parameter int POOL_DEPTH = 4,
  parameter int QDEPTH     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic              push_ready_o,
  output logic              push_err_o,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic              pop_err_o,
  input  logic [1:0]        done_i,
  output logic [ADDR_W-1:0] slot0_addr_o,
  output logic [ADDR_W-1:0] slot1_addr_o,
  output logic [1:0]        active_o,
  output logic              running_o,
  output logic              start_err_o,
  output logic              frame_done_o
);

  localparam int CW = $clog2(POOL_DEPTH + 1);
  localparam int QW = $clog2(QDEPTH + 1);

  logic [1:0]        pool_push_n, pool_pop_n;
  logic [ADDR_W-1:0] pool_push_a, pool_push_b, pool_top, pool_second;
  logic [CW-1:0]     pool_cnt;
  logic              ring_wr;
  logic [ADDR_W-1:0] ring_addr;
  logic [QW-1:0]     ring_level;
  logic              ev_queue, ev_reload, ev_share, ev_skip;

  fbr_pool #(.AW(ADDR_W), .DEPTH(POOL_DEPTH), .CW(CW)) i_pool (
    .clk(clk), .rst_n(rst_n),
    .push_n_i(pool_push_n), .push_a_i(pool_push_a), .push_b_i(pool_push_b),
    .pop_n_i(pool_pop_n), .cnt_o(pool_cnt), .top_o(pool_top), .second_o(pool_second)
  );

  fbr_ring #(.AW(ADDR_W), .QDEPTH(QDEPTH), .QW(QW)) i_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_i(ring_wr), .wr_addr_i(ring_addr), .rd_i(pop_i),
    .rd_valid_o(pop_valid_o), .rd_addr_o(pop_addr_o), .rd_err_o(pop_err_o),
    .level_o(ring_level)
  );

  fbr_ctrl #(.AW(ADDR_W), .DEPTH(POOL_DEPTH), .QDEPTH(QDEPTH), .CW(CW), .QW(QW)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .stop_i(stop_i), .push_i(push_i), .push_addr_i(push_addr_i),
    .done_i(done_i), .pool_cnt_i(pool_cnt), .pool_top_i(pool_top),
    .pool_second_i(pool_second), .ring_level_i(ring_level),
    .pool_push_n_o(pool_push_n), .pool_push_a_o(pool_push_a), .pool_push_b_o(pool_push_b),
    .pool_pop_n_o(pool_pop_n), .ring_wr_o(ring_wr), .ring_addr_o(ring_addr),
    .ev_queue_o(ev_queue), .ev_reload_o(ev_reload), .ev_share_o(ev_share),
    .ev_skip_o(ev_skip), .push_ready_o(push_ready_o), .push_err_o(push_err_o),
    .slot0_addr_o(slot0_addr_o), .slot1_addr_o(slot1_addr_o), .active_o(active_o),
    .running_o(running_o), .start_err_o(start_err_o), .frame_done_o(frame_done_o)
  );

endmodule

// File: rtl/fbr_checks.sv
module fbr_checks #(
  parameter int AW     = 32,
  parameter int CW     = 3,
  parameter int QW     = 2,
  parameter int QDEPTH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          stop_i,
  input logic          push_i,
  input logic          push_ready_o,
  input logic          push_err_o,
  input logic          pop_i,
  input logic          pop_valid_o,
  input logic          pop_err_o,
  input logic [1:0]    done_i,
  input logic [AW-1:0] slot0_addr_o,
  input logic [AW-1:0] slot1_addr_o,
  input logic [1:0]    active_o,
  input logic          running_o,
  input logic          start_err_o,
  input logic          frame_done_o,
  input logic [CW-1:0] pool_cnt,
  input logic [AW-1:0] pool_top,
  input logic [AW-1:0] pool_second,
  input logic [QW-1:0] ring_level,
  input logic          ev_queue,
  input logic          ev_share
);

  p_act_max_r2: assert property (@(posedge clk) disable iff (!rst_n) active_o <= 2'd2);

  p_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !stop_i && !running_o && pool_cnt < CW'(2) |=> start_err_o && !running_o);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !stop_i && !running_o && pool_cnt >= CW'(2) |=>
      running_o && active_o == 2'd2 &&
      slot0_addr_o == $past(pool_top) && slot1_addr_o == $past(pool_second));

  p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && !stop_i && done_i == 2'b11 |=>
      !frame_done_o && $stable(slot0_addr_o) && $stable(slot1_addr_o) && $stable(active_o));

  p_queue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_queue && !(pop_i && ring_level != '0) |=> ring_level == $past(ring_level) + QW'(1));

  p_share_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_share |=> slot0_addr_o == slot1_addr_o && active_o == 2'd1);

  p_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && !stop_i && (done_i[0] ^ done_i[1]) && active_o == 2'd2 &&
    ring_level == QW'(QDEPTH) |=> !frame_done_o && active_o == 2'd2);

  p_pop_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && ring_level == '0 |=> pop_err_o && !pop_valid_o);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && running_o |=> !running_o && active_o == 2'd0);

  p_push_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !push_ready_o |=> push_err_o);

  p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o && !start_i && done_i != 2'b00 |=>
      !frame_done_o && $stable(slot0_addr_o) && $stable(slot1_addr_o));

endmodule

bind fbuf_recycler fbr_checks #(.AW(ADDR_W), .CW(CW), .QW(QW), .QDEPTH(QDEPTH)) i_checks (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .push_i(push_i),
  .push_ready_o(push_ready_o), .push_err_o(push_err_o), .pop_i(pop_i),
  .pop_valid_o(pop_valid_o), .pop_err_o(pop_err_o), .done_i(done_i),
  .slot0_addr_o(slot0_addr_o), .slot1_addr_o(slot1_addr_o), .active_o(active_o),
  .running_o(running_o), .start_err_o(start_err_o), .frame_done_o(frame_done_o),
  .pool_cnt(pool_cnt), .pool_top(pool_top), .pool_second(pool_second),
  .ring_level(ring_level), .ev_queue(ev_queue), .ev_share(ev_share)
);

// File: tb/test_fbuf_recycler.sv
module test_fbuf_recycler;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, stop_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [1:0]    done_i = 2'b00;
  logic          push_ready_o, push_err_o, pop_valid_o, pop_err_o;
  logic [AW-1:0] pop_addr_o, slot0_addr_o, slot1_addr_o;
  logic [1:0]    active_o;
  logic          running_o, start_err_o, frame_done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [AW-1:0] exp_q [$];

  localparam logic [AW-1:0] A = 32'hA000_1000, B = 32'hA000_2000, C = 32'hA000_3000,
                            D = 32'hA000_4000, E = 32'hA000_5000, F = 32'hA000_6000,
                            G = 32'hA000_7000, H = 32'hA000_8000, I = 32'hA000_9000,
                            J = 32'hA000_A000, Z = 32'hA000_F000;

  fbuf_recycler #(.ADDR_W(AW), .POOL_DEPTH(4), .QDEPTH(3)) i_fbuf_recycler (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .push_i(push_i),
    .push_addr_i(push_addr_i), .push_ready_o(push_ready_o), .push_err_o(push_err_o),
    .pop_i(pop_i), .pop_valid_o(pop_valid_o), .pop_addr_o(pop_addr_o), .pop_err_o(pop_err_o),
    .done_i(done_i), .slot0_addr_o(slot0_addr_o), .slot1_addr_o(slot1_addr_o),
    .active_o(active_o), .running_o(running_o), .start_err_o(start_err_o),
    .frame_done_o(frame_done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compares every popped address with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && pop_valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected pop", pop_addr_o, '0);
      else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        chk(pop_addr_o == e, "R8 pop order", pop_addr_o, e);
      end
    end
  end

  task automatic do_push(input logic [AW-1:0] a);
    push_i = 1'b1; push_addr_i = a;
    @(negedge clk);
    push_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  // Raise done; when a buffer is expected to be queued, record it on the scoreboard.
  task automatic do_done(input logic [1:0] d, input bit queued, input logic [AW-1:0] a);
    done_i = d;
    if (queued) exp_q.push_back(a);
    @(negedge clk);
    done_i = 2'b00;
    chk(frame_done_o == queued, "R12 frame_done pulse", 32'(frame_done_o), 32'(queued));
  endtask

  task automatic do_pop(input bit expect_err);
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    chk(pop_err_o == expect_err, "R9 pop error flag", 32'(pop_err_o), 32'(expect_err));
  endtask

  task automatic slots(input string req, input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                       input logic [1:0] act);
    chk(slot0_addr_o == s0, req, slot0_addr_o, s0);
    chk(slot1_addr_o == s1, req, slot1_addr_o, s1);
    chk(active_o == act, req, 32'(active_o), 32'(act));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    slots("reset slots", '0, '0, 2'd0);
    chk(!running_o && push_ready_o, "reset idle", 32'(running_o), 0);

    // R1: refused with empty pool and with one entry
    do_start();
    chk(start_err_o && !running_o, "R1 start refused empty", 32'(start_err_o), 1);
    do_push(A);
    do_start();
    chk(start_err_o && !running_o, "R1 start refused one", 32'(start_err_o), 1);
    do_push(B); do_push(C);
    do_start();
    chk(running_o && !start_err_o, "R1 start accepted", 32'(running_o), 1);
    slots("R1 start loads top into slot 0", C, B, 2'd2);
    do_start();
    chk(start_err_o, "R1 start refused while running", 32'(start_err_o), 1);

    // R4 R5: slot 0 done, queue C, reload from pool (D on top)
    do_push(D);
    do_done(2'b01, 1'b1, C);
    slots("R5 reload slot 0", D, B, 2'd2);
    // R3: both flags skipped
    do_done(2'b11, 1'b0, '0);
    slots("R3 dual done skipped", D, B, 2'd2);
    // R4 slot 1 done: queue B, reload with A
    do_done(2'b10, 1'b1, B);
    slots("R4 R2 slot 1 reload", D, A, 2'd2);
    // R6: pool empty, share
    do_done(2'b01, 1'b1, D);
    slots("R6 share other slot", A, A, 2'd1);
    do_done(2'b10, 1'b0, '0);
    slots("R6 share with one active", A, A, 2'd1);
    // R5: refill pool, slot 0 reloaded
    do_push(E);
    do_done(2'b01, 1'b0, '0);
    slots("R5 reload from one active", E, A, 2'd2);
    // R7: queue full (C,B,D)
    do_done(2'b10, 1'b0, '0);
    slots("R7 full queue keeps slot", E, A, 2'd2);

    // R8 R9: drain
    do_pop(1'b0); do_pop(1'b0); do_pop(1'b0);
    do_pop(1'b1);

    // R8 wrap-around
    do_done(2'b01, 1'b1, E);
    slots("R6 share after wrap write", A, A, 2'd1);
    do_push(F);
    do_done(2'b10, 1'b0, '0);
    slots("R5 reload slot 1", A, F, 2'd2);
    do_done(2'b01, 1'b1, A);
    slots("R6 share slot 0", F, F, 2'd1);
    do_pop(1'b0); do_pop(1'b0);

    // R11: push colliding with done is refused
    push_i = 1'b1; push_addr_i = Z; done_i = 2'b11;
    #1;
    chk(!push_ready_o, "R11 push_ready low on collision", 32'(push_ready_o), 0);
    @(negedge clk);
    push_i = 1'b0; done_i = 2'b00;
    chk(push_err_o, "R11 push refused on collision", 32'(push_err_o), 1);

    // R10: stop with one active returns F only; Z was not stored
    do_stop();
    chk(!running_o && active_o == 2'd0, "R10 stop clears", 32'(active_o), 0);
    do_start();
    chk(start_err_o, "R10 R11 pool holds one entry", 32'(start_err_o), 1);
    do_push(G); do_push(H);
    do_start();
    slots("R1 restart", H, G, 2'd2);
    do_stop();
    do_start();
    slots("R10 stop returns slot 0 then slot 1", G, H, 2'd2);
    do_stop();
    // pool F,G,H -> fill to four
    do_push(I);
    chk(!push_err_o, "R11 push into last room", 32'(push_err_o), 0);
    do_push(J);
    chk(push_err_o, "R11 push refused when full", 32'(push_err_o), 1);

    // R13: done while idle
    do_done(2'b01, 1'b0, '0);
    slots("R13 done ignored idle", G, H, 2'd0);
    do_pop(1'b1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8 scoreboard drained", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule